// File: doc/BRIEF.md
# Synchronous Burst SRAM Model

This block is a synthesizable model of a single-port synchronous SRAM that can run short bursts. Its storage depth is a parameter. Each word holds two 9-bit byte lanes. The address, chip enable, the two start strobes, the burst-step control, the write controls and the write data are all captured on the rising clock edge. Output enable and the sleep request act at once, without waiting for a clock.

Either start strobe loads a new external address. A load can happen on any cycle, so the block supports back-to-back random accesses at full rate. After a load, the burst-step input moves a 2-bit beat counter forward. The beat counter changes only the two low address bits, and it does so in one of two orders, chosen by a level input: interleaved (XOR) or linear (add modulo 4). A mode input chooses how reads are timed:
- **Flow-through:** data appears right after the capturing edge.
- **Pipelined:** data passes through an output register and appears one edge later.

A start strobe with chip enable low deselects the block. The read path carries the deselect just like a read, so the outputs go quiet only after the second edge.

Top module: `sync_burst_sram`

## Requirements
- R1: After reset, and until a read reaches the output stage, `dout_en` is 0.
- R2: A rising edge with `strobe_a` or `strobe_b` high and `chip_en` high starts an access at `addr`. This works on consecutive cycles, with no idle cycle in between.
- R3: With `order_linear`=0, the k-th beat after a load (k = 0..3, counting the load as beat 0) accesses low bits `addr[1:0] XOR k`. The upper bits keep the loaded value.
- R4: With `order_linear`=1, the k-th beat accesses low bits `(addr[1:0] + k) mod 4`. The upper bits keep the loaded value.
- R5: With `pipe_mode`=0, read data and `dout_en`=1 are present right after the edge that captured the read. With `pipe_mode`=1, they appear only after the following edge.
- R6: When `all_wr`=1 on an active cycle, both lanes are written, whatever `byte_wr_en` and `byte_sel` hold.
- R7: When `all_wr`=0, lane i is written only if `byte_wr_en`=1 and `byte_sel[i]`=1. Lane 0 is `din[8:0]` and lane 1 is `din[17:9]`. With `byte_wr_en`=0, the word is left unchanged.
- R8: After a start strobe with `chip_en`=0 that follows a read, `dout_en` stays 1 and the last read data stays on `dout` through the cycle after that edge. `dout_en` drops after the next edge.
- R9: `out_en`=0 forces `dout_en` to 0 at once, with no clock needed.
- R10: `sleep`=1 forces `dout_en` to 0 at once. While `sleep` is high, all commands and writes are ignored and the memory keeps its contents. After release, the block carries on from the state it had before sleep.
- R11: A write cycle never drives `dout_en` in the output slot that a read on that cycle would have used.
- R12: A fifth beat, without a new load, wraps the counter back to the loaded address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of control state |
| addr | input | ADDR_W | External word address |
| chip_en | input | 1 | Select: with a start strobe, high starts an access and low deselects |
| strobe_a | input | 1 | Start strobe, first source |
| strobe_b | input | 1 | Start strobe, second source |
| burst_step | input | 1 | Advance the beat counter when no strobe is present |
| all_wr | input | 1 | Write all lanes |
| byte_wr_en | input | 1 | Enable lane-selective write |
| byte_sel | input | NUM_BYTES | Per-lane write select |
| din | input | NUM_BYTES*BYTE_W | Write data |
| order_linear | input | 1 | Beat order: 0 interleaved, 1 linear |
| pipe_mode | input | 1 | Read timing: 0 flow-through, 1 pipelined |
| out_en | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Asynchronous low-power request |
| dout | output | NUM_BYTES*BYTE_W | Read data |
| dout_en | output | 1 | Read data is being driven |

## Verification
Two kinds of internal fault show up at the data port within one or two edges of the command that triggers them:
- A wrong beat counter or wrong order logic makes `dout` return a neighbouring word during a burst.
- A corrupted lane mask shows up as soon as the word is read back and compared with the reference copy.

Faults in the stage that tracks valid and write status show up only in the timing of `dout_en`. Examples are a missing pipeline register, or a deselect that is not carried one extra cycle. Such a fault makes `dout_en` rise one edge early, drop one edge early, or go high during a write slot. The bench therefore samples `dout_en` at every edge around loads, deselects and writes, in both read modes.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

   localparam int unsigned BEAT_W = 2;

   typedef logic [BEAT_W-1:0] beat_t;

   typedef struct packed {
      logic vld;
      logic wr;
   } stage_t;

   function automatic beat_t beat_offset(input logic lin, input beat_t start, input beat_t cnt);
      return lin ? beat_t'(start + cnt) : (start ^ cnt);
   endfunction

endpackage

// File: rtl/sbsram_burst.sv
module sbsram_burst
   import sbsram_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold,
   input  logic              load,
   input  logic              step,
   input  logic              linear,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] nxt_addr
);

   localparam int UP_W = ADDR_W - BEAT_W;

   logic [ADDR_W-1:0] base_q, base_d;
   beat_t             cnt_q, cnt_d;

   always_comb begin
      base_d = load ? addr_in : base_q;
      if (load)      cnt_d = '0;
      else if (step) cnt_d = beat_t'(cnt_q + 1'b1);
      else           cnt_d = cnt_q;
      nxt_addr = {base_d[ADDR_W-1:BEAT_W], beat_offset(linear, base_d[BEAT_W-1:0], cnt_d)};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         cnt_q  <= '0;
      end else if (!hold) begin
         base_q <= base_d;
         cnt_q  <= cnt_d;
      end
   end

   // R3 / R4: beats never disturb the upper address bits
   a_r3_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      (!load) |-> (nxt_addr[ADDR_W-1 -: UP_W] == base_q[ADDR_W-1 -: UP_W]));

endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
   parameter int ADDR_W    = 6,
   parameter int BYTE_W    = 9,
   parameter int NUM_BYTES = 2
) (
   input  logic                        clk,
   input  logic [NUM_BYTES-1:0]        we,
   input  logic [ADDR_W-1:0]           waddr,
   input  logic [NUM_BYTES*BYTE_W-1:0] wdata,
   input  logic [ADDR_W-1:0]           raddr,
   output logic [NUM_BYTES*BYTE_W-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   for (genvar ln = 0; ln < NUM_BYTES; ln++) begin : g_lane
      logic [BYTE_W-1:0] store [DEPTH];

      always_ff @(posedge clk) begin
         if (we[ln]) store[waddr] <= wdata[ln*BYTE_W +: BYTE_W];
      end

      assign rdata[ln*BYTE_W +: BYTE_W] = store[raddr];
   end

endmodule

// File: rtl/sbsram_outstage.sv
module sbsram_outstage
   import sbsram_pkg::*;
#(
   parameter int WORD_W = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sleep,
   input  logic              pipe_mode,
   input  logic              out_en,
   input  stage_t            cmd,
   input  logic [WORD_W-1:0] rd_word,
   output logic [WORD_W-1:0] dout,
   output logic              dout_en
);

   stage_t            s1_q, s2_q;
   logic [WORD_W-1:0] dout_q;
   logic              rd_vis;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_q   <= '0;
         s2_q   <= '0;
         dout_q <= '0;
      end else if (!sleep) begin
         s1_q   <= cmd;
         s2_q   <= s1_q;
         dout_q <= rd_word;
      end
   end

   always_comb begin
      if (pipe_mode) rd_vis = s2_q.vld && !s2_q.wr;
      else           rd_vis = (s1_q.vld && !s1_q.wr) || (!s1_q.vld && s2_q.vld && !s2_q.wr);
      dout    = pipe_mode ? dout_q : rd_word;
      dout_en = out_en && !sleep && rd_vis;
   end

   // R9: output enable gates the drive
   a_r9_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_en) |-> (!dout_en));

   // R10: nothing is driven while asleep
   a_r10_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> (!dout_en));

   // R11: a flow-through write slot stays silent
   a_r11_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (!pipe_mode && s1_q.vld && s1_q.wr) |-> (!dout_en));

   // R8: a read followed by a deselect is still visible one cycle later
   a_r8_dcd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && s1_q.vld && !s1_q.wr && !cmd.vld) |=> rd_vis);

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
   import sbsram_pkg::*;
#(
   parameter int ADDR_W    = 6,
   parameter int BYTE_W    = 9,
   parameter int NUM_BYTES = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [ADDR_W-1:0]           addr,
   input  logic                        chip_en,
   input  logic                        strobe_a,
   input  logic                        strobe_b,
   input  logic                        burst_step,
   input  logic                        all_wr,
   input  logic                        byte_wr_en,
   input  logic [NUM_BYTES-1:0]        byte_sel,
   input  logic [NUM_BYTES*BYTE_W-1:0] din,
   input  logic                        order_linear,
   input  logic                        pipe_mode,
   input  logic                        out_en,
   input  logic                        sleep,
   output logic [NUM_BYTES*BYTE_W-1:0] dout,
   output logic                        dout_en
);

   localparam int WORD_W = NUM_BYTES * BYTE_W;

   initial begin
      if (ADDR_W <= int'(BEAT_W)) $fatal(1, "ADDR_W must exceed the beat counter width");
      if (NUM_BYTES < 1 || BYTE_W < 1) $fatal(1, "lane geometry must be non-empty");
   end

   logic                 strobe, act_q, nxt_act, step_ok;
   logic [NUM_BYTES-1:0] lane_we;
   logic [ADDR_W-1:0]    nxt_addr, acc_q;
   logic [WORD_W-1:0]    rd_word;
   stage_t               cmd;

   always_comb begin
      strobe  = strobe_a || strobe_b;
      nxt_act = strobe ? chip_en : act_q;
      step_ok = burst_step && act_q && !strobe;
      lane_we = '0;
      if (!sleep && nxt_act) begin
         if (all_wr)          lane_we = '1;
         else if (byte_wr_en) lane_we = byte_sel;
      end
      cmd.vld = nxt_act;
      cmd.wr  = |lane_we;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         acc_q <= '0;
      end else if (!sleep) begin
         act_q <= nxt_act;
         if (nxt_act) acc_q <= nxt_addr;
      end
   end

   sbsram_burst #(.ADDR_W(ADDR_W)) u_burst (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold     (sleep),
      .load     (strobe && chip_en),
      .step     (step_ok),
      .linear   (order_linear),
      .addr_in  (addr),
      .nxt_addr (nxt_addr)
   );

   sbsram_array #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_array (
      .clk   (clk),
      .we    (lane_we),
      .waddr (nxt_addr),
      .wdata (din),
      .raddr (acc_q),
      .rdata (rd_word)
   );

   sbsram_outstage #(.WORD_W(WORD_W)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .sleep     (sleep),
      .pipe_mode (pipe_mode),
      .out_en    (out_en),
      .cmd       (cmd),
      .rd_word   (rd_word),
      .dout      (dout),
      .dout_en   (dout_en)
   );

   // R10: sleep blocks every write strobe into the array
   a_r10_no_write_asleep: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> (lane_we == '0));

   // R7: without a global write, a lane is never written outside its select
   a_r7_lane_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (!all_wr) |-> ((lane_we & ~byte_sel) == '0));

endmodule

// File: tb/sync_burst_sram_test.sv
module sync_burst_sram_test;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 6;
   localparam int WW = 18;

   // {order_linear, start, beats packed as {b3,b2,b1,b0}}
   localparam logic [10:0] VECS [8] = '{
      {1'b0, 2'd0, 8'b11_10_01_00},
      {1'b0, 2'd1, 8'b10_11_00_01},
      {1'b0, 2'd2, 8'b01_00_11_10},
      {1'b0, 2'd3, 8'b00_01_10_11},
      {1'b1, 2'd0, 8'b11_10_01_00},
      {1'b1, 2'd1, 8'b00_11_10_01},
      {1'b1, 2'd2, 8'b01_00_11_10},
      {1'b1, 2'd3, 8'b10_01_00_11}
   };

   logic          clk = 1'b0;
   logic          rst_n;
   logic [AW-1:0] addr;
   logic          chip_en, strobe_a, strobe_b, burst_step;
   logic          all_wr, byte_wr_en;
   logic [1:0]    byte_sel;
   logic [WW-1:0] din;
   logic          order_linear, pipe_mode, out_en, sleep;
   logic [WW-1:0] dout;
   logic          dout_en;

   logic [WW-1:0] ref_mem [64];
   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sync_burst_sram uut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .chip_en(chip_en),
      .strobe_a(strobe_a), .strobe_b(strobe_b), .burst_step(burst_step),
      .all_wr(all_wr), .byte_wr_en(byte_wr_en), .byte_sel(byte_sel), .din(din),
      .order_linear(order_linear), .pipe_mode(pipe_mode), .out_en(out_en),
      .sleep(sleep), .dout(dout), .dout_en(dout_en)
   );

   task automatic chk(input logic ok, input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic set_idle();
      strobe_a = 0; strobe_b = 0; chip_en = 0; burst_step = 0;
      all_wr = 0; byte_wr_en = 0; byte_sel = 0;
   endtask

   task automatic issue_write(input logic [AW-1:0] a, input logic [WW-1:0] d,
                              input logic gw, input logic be, input logic [1:0] sel);
      set_idle();
      strobe_a = 1; chip_en = 1; addr = a; din = d;
      all_wr = gw; byte_wr_en = be; byte_sel = sel;
      for (int ln = 0; ln < 2; ln++)
         if (gw || (be && sel[ln])) ref_mem[a][ln*9 +: 9] = d[ln*9 +: 9];
   endtask

   task automatic issue_read(input logic [AW-1:0] a, input logic use_b);
      set_idle();
      chip_en = 1; addr = a;
      if (use_b) strobe_b = 1; else strobe_a = 1;
   endtask

   task automatic issue_deselect();
      set_idle();
      strobe_a = 1; chip_en = 0;
   endtask

   function automatic logic [WW-1:0] pat(input int a);
      return WW'((a * 1237 + 91) ^ (a << 11));
   endfunction

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      rst_n = 0; set_idle(); addr = '0; din = '0;
      order_linear = 0; pipe_mode = 0; out_en = 1; sleep = 0;
      for (int i = 0; i < 64; i++) ref_mem[i] = '0;
      repeat (3) tick();
      chk(dout_en == 1'b0, "R1 during reset", WW'(dout_en), '0);
      rst_n = 1;
      tick();
      chk(dout_en == 1'b0, "R1 after reset", WW'(dout_en), '0);

      // R6 / R2: back-to-back global writes fill the array
      for (int a = 0; a < 64; a++) begin
         issue_write(AW'(a), pat(a), 1'b1, 1'b0, 2'b00);
         tick();
      end
      // R2: back-to-back flow-through reads alternating strobes
      for (int a = 0; a < 64; a++) begin
         issue_read(AW'(a), a[0]);
         tick();
         chk(dout_en && dout == ref_mem[a], "R2 random read", dout, ref_mem[a]);
      end

      // R3 / R4 / R12: burst order vectors
      for (int v = 0; v < 8; v++) begin
         logic [3:0] up;
         logic [7:0] seq;
         string rq;
         up  = 4'(v + 3);
         seq = VECS[v][7:0];
         rq  = VECS[v][10] ? "R4 linear beat" : "R3 interleaved beat";
         order_linear = VECS[v][10];
         issue_read({up, VECS[v][9:8]}, 1'b0);
         tick();
         chk(dout == ref_mem[{up, seq[1:0]}], rq, dout, ref_mem[{up, seq[1:0]}]);
         for (int b = 1; b < 4; b++) begin
            set_idle(); burst_step = 1;
            tick();
            chk(dout_en && dout == ref_mem[{up, seq[b*2 +: 2]}], rq, dout, ref_mem[{up, seq[b*2 +: 2]}]);
         end
         tick();
         chk(dout == ref_mem[{up, seq[1:0]}], "R12 wrap", dout, ref_mem[{up, seq[1:0]}]);
         set_idle();
      end
      order_linear = 0;

      // R5 / R8 pipelined
      pipe_mode = 1;
      issue_deselect(); tick();
      set_idle(); tick(); tick();
      chk(dout_en == 1'b0, "R8 quiet after deselect", WW'(dout_en), '0);
      issue_read(6'd17, 1'b1); tick();
      chk(dout_en == 1'b0, "R5 pipelined not yet", WW'(dout_en), '0);
      set_idle(); tick();
      chk(dout_en && dout == ref_mem[17], "R5 pipelined data", dout, ref_mem[17]);
      issue_deselect(); tick();
      chk(dout_en && dout == ref_mem[17], "R8 pipelined hold", dout, ref_mem[17]);
      set_idle(); tick();
      chk(dout_en == 1'b0, "R8 pipelined off", WW'(dout_en), '0);

      // R11 pipelined write slot
      issue_write(6'd20, 18'h2C3A5, 1'b1, 1'b0, 2'b00); tick();
      set_idle(); tick();
      chk(dout_en == 1'b0, "R11 pipelined write slot", WW'(dout_en), '0);
      tick();
      chk(dout_en && dout == ref_mem[20], "R5 pipelined read after write", dout, ref_mem[20]);

      // R5 / R8 flow-through
      pipe_mode = 0;
      issue_deselect(); tick(); set_idle(); tick(); tick();
      issue_read(6'd33, 1'b0); tick();
      chk(dout_en && dout == ref_mem[33], "R5 flow-through same slot", dout, ref_mem[33]);
      issue_deselect(); tick();
      chk(dout_en && dout == ref_mem[33], "R8 flow-through hold", dout, ref_mem[33]);
      set_idle(); tick();
      chk(dout_en == 1'b0, "R8 flow-through off", WW'(dout_en), '0);

      // R6 / R7 lane writes against the reference array
      issue_write(6'd7, 18'h00000, 1'b1, 1'b0, 2'b00); tick();
      chk(dout_en == 1'b0, "R11 flow-through write slot", WW'(dout_en), '0);
      issue_write(6'd7, 18'h3FFFF, 1'b0, 1'b1, 2'b01); tick();
      issue_read(6'd7, 1'b0); tick();
      chk(dout == ref_mem[7] && dout == 18'h001FF, "R7 low lane only", dout, 18'h001FF);
      issue_write(6'd7, 18'h00000, 1'b0, 1'b0, 2'b10); tick();
      issue_read(6'd7, 1'b1); tick();
      chk(dout == ref_mem[7] && dout == 18'h001FF, "R7 no enable no change", dout, 18'h001FF);
      issue_write(6'd7, {9'h155, 9'h0AA}, 1'b0, 1'b1, 2'b10); tick();
      issue_read(6'd7, 1'b0); tick();
      chk(dout == ref_mem[7] && dout == {9'h155, 9'h1FF}, "R7 high lane only", dout, {9'h155, 9'h1FF});
      issue_write(6'd7, {9'h0F0, 9'h00F}, 1'b1, 1'b0, 2'b00); tick();
      issue_read(6'd7, 1'b0); tick();
      chk(dout == ref_mem[7] && dout == {9'h0F0, 9'h00F}, "R6 global overrides lanes", dout, {9'h0F0, 9'h00F});

      // R9 asynchronous output enable
      set_idle();
      out_en = 0; #1;
      chk(dout_en == 1'b0, "R9 enable low", WW'(dout_en), '0);
      out_en = 1; #1;
      chk(dout_en == 1'b1, "R9 enable restored", WW'(dout_en), 18'h1);

      // R10 sleep
      issue_read(6'd9, 1'b0); tick();
      set_idle();
      sleep = 1; #1;
      chk(dout_en == 1'b0, "R10 sleep drops drive", WW'(dout_en), '0);
      strobe_a = 1; chip_en = 1; addr = 6'd9; all_wr = 1; din = 18'h12345;
      tick();
      addr = 6'd40;
      tick();
      chk(dout_en == 1'b0, "R10 asleep", WW'(dout_en), '0);
      set_idle();
      sleep = 0; #1;
      chk(dout_en && dout == ref_mem[9], "R10 state kept", dout, ref_mem[9]);
      tick();
      chk(dout_en && dout == ref_mem[9], "R10 memory kept", dout, ref_mem[9]);
      issue_read(6'd40, 1'b1); tick();
      chk(dout == ref_mem[40], "R10 other word kept", dout, ref_mem[40]);

      summary();
      $finish;
   end

endmodule